// File: doc/BRIEF.md
# Second-Level Cache Tag Lookup Controller

This block makes the hit or miss decision for an external direct-mapped second-level cache whose tags sit in a separate tag SRAM. A request comes from the processor or from a PCI initiator. It carries a line address, a read/write flag, a valid strobe and a source flag. The block drives the tag SRAM index in the cycle it accepts the request. It compares the tag word returned one cycle later against the upper address bits. It then answers with a single-cycle done pulse that carries the hit flag, any tag SRAM write, and any request for a DRAM write.

Static configuration inputs choose the cache size (256 KB to 2 MB), the tag width (7 to 10 bits) and the write policy. In the write-through policy a write hit is passed on to DRAM at once. In the writeback policy the tag is held at 7 bits and the tag word bit just above it serves as a per-line modify flag. A write hit only sets that flag. A read miss that would overwrite a modified line first raises a victim writeback request, and waits for its acknowledge before the new tag is written.

The range of cacheable addresses follows from the cache size and the tag width. Requests at or above that limit are treated as misses and never touch the tag store.

Top module: `l2tag_ctrl`

## Requirements
- R1: `cfg_size` codes 0, 1, 2 and 3 select 256 KB, 512 KB, 1 MB and 2 MB. In the cycle a request is accepted, `tag_idx` equals the address bits A[17+s:5] for size code s, zero-extended to 16 bits. The same value is held until the done pulse ends.
- R2: In write-through mode (`cfg_wb`=0) the tag width is W = 7 + `cfg_tag_mode`. Address bits A[17+s+W:18+s] are compared with bits [W-1:0] of `tag_rdata`. Tag word bits at or above W do not affect the result.
- R3: The cacheable limit is 2^(18+s+W) minus 2^(18+s) bytes. A request at or above it reports a miss. It writes no tag and raises no victim request.
- R4: A request is accepted when `req_valid` is high at a clock edge while the block is idle. `resp_done` is high for exactly one cycle, starting at the second edge after acceptance (later if a victim writeback is pending). `req_valid` while busy is ignored.
- R5: A read hit reports `resp_hit`=1, with no tag write and no DRAM write, under either policy.
- R6: A write hit in write-through mode raises `dram_wr_req` with the done pulse and writes no tag.
- R7: In writeback mode (`cfg_wb`=1) the tag width is 7 whatever `cfg_tag_mode` holds, and tag word bit 7 is the modify flag. A write hit writes the tag word {bit 7 = 1, tag in bits [6:0]}, and `dram_wr_req` stays low.
- R8: A cacheable read miss allocates the line. It writes the new tag in bits [W-1:0], with all higher bits (including the modify flag) zero, and reports `resp_hit`=0.
- R9: A write that misses, whether cacheable or not, allocates nothing. It raises `dram_wr_req` with the done pulse and writes no tag.
- R10: In writeback mode, a cacheable read miss whose stored modify flag is set first raises `victim_req`. At that point `victim_addr` = (stored tag << (18+s)) | (A[17+s:5] << 5). `victim_req` stays high until `victim_ack` is sampled. At that edge the new clean tag is written and `resp_done` is given.
- R11: `resp_pci` during the done pulse equals the source flag of the request being answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | 32 | Byte address of the access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_pci | input | 1 | 1 = PCI initiator, 0 = processor |
| cfg_size | input | 2 | Cache size code |
| cfg_tag_mode | input | 2 | Tag width minus 7 (write-through only) |
| cfg_wb | input | 1 | 1 = writeback with modify flag |
| tag_rdata | input | 10 | Tag SRAM read word, one cycle after index |
| victim_ack | input | 1 | Victim writeback accepted |
| tag_idx | output | 16 | Tag SRAM index |
| tag_wdata | output | 10 | Tag SRAM write word |
| tag_we | output | 1 | Tag SRAM write enable |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_hit | output | 1 | Hit flag, valid with done |
| resp_pci | output | 1 | Source of the answered request |
| dram_wr_req | output | 1 | DRAM write request, with done |
| victim_req | output | 1 | Dirty victim writeback request |
| victim_addr | output | 32 | Line address of the victim |

## Verification
On every cycle, the assertions check the following. The done pulse lasts one cycle. An uncacheable lookup writes no tag. A read hit writes nothing, and a write hit goes to DRAM only under write-through. The victim request holds until acknowledged, and the clean tag write follows its release in the same cycle. Only the bench's scenarios can show the outcomes that depend on stored state. These are the bit slices chosen for each size and width, the exact limit boundary, the modify flag surviving a second write, the victim address built from an earlier allocation, and requests ignored while busy.

// File: rtl/l2tag_pkg.sv
package l2tag_pkg;
  localparam int ADDR_W      = 32;
  localparam int LINE_LSB    = 5;
  localparam int SET_LSB_MIN = 18;
  localparam int SIZE_CODES  = 4;
  localparam int TAG_BASE    = 7;
  localparam int TAG_WORD    = 10;
  localparam int IDX_W       = SET_LSB_MIN - LINE_LSB + SIZE_CODES - 1;
  localparam int WIDTH_W     = $clog2(TAG_WORD + 1);

  typedef logic [ADDR_W-1:0]   addr_t;
  typedef logic [IDX_W-1:0]    idx_t;
  typedef logic [TAG_WORD-1:0] tword_t;
  typedef logic [1:0]          size_t;
  typedef logic [WIDTH_W-1:0]  twidth_t;

  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_VICT, ST_RESP} state_t;

  // lowest address bit that belongs to the tag
  function automatic int f_shift(size_t s);
    return SET_LSB_MIN + int'(s);
  endfunction

  // compared tag width; writeback keeps 7 bits and frees one for the modify flag
  function automatic twidth_t f_width(logic [1:0] mode, logic wb);
    return wb ? twidth_t'(TAG_BASE) : twidth_t'(TAG_BASE + int'(mode));
  endfunction

  function automatic idx_t f_index(addr_t a, size_t s);
    addr_t m;
    m = (addr_t'(1) << (f_shift(s) - LINE_LSB)) - addr_t'(1);
    return idx_t'((a >> LINE_LSB) & m);
  endfunction

  function automatic tword_t f_tag(addr_t a, size_t s, twidth_t w);
    addr_t m;
    m = (addr_t'(1) << w) - addr_t'(1);
    return tword_t'((a >> f_shift(s)) & m);
  endfunction

  // first uncacheable byte address: span covered by the tag less one cache size
  function automatic logic [ADDR_W:0] f_limit(size_t s, twidth_t w);
    logic [ADDR_W:0] one;
    one = {{ADDR_W{1'b0}}, 1'b1};
    return (one << (f_shift(s) + int'(w))) - (one << f_shift(s));
  endfunction

  function automatic addr_t f_line(tword_t t, idx_t i, size_t s);
    return (addr_t'(t) << f_shift(s)) | (addr_t'(i) << LINE_LSB);
  endfunction
endpackage

// File: rtl/l2tag_decode.sv
module l2tag_decode
  import l2tag_pkg::*;
(
  input  addr_t      addr,
  input  size_t      size,
  input  logic [1:0] mode,
  input  logic       wb,
  output idx_t       idx,
  output tword_t     tag,
  output twidth_t    width,
  output logic       cacheable
);
  logic [ADDR_W:0] limit;

  assign width     = f_width(mode, wb);
  assign idx       = f_index(addr, size);
  assign tag       = f_tag(addr, size, width);
  assign limit     = f_limit(size, width);
  assign cacheable = ({1'b0, addr} < limit);
endmodule

// File: rtl/l2tag_compare.sv
module l2tag_compare
  import l2tag_pkg::*;
(
  input  tword_t  stored,
  input  tword_t  tag,
  input  twidth_t width,
  input  logic    wb,
  output logic    match,
  output logic    dirty,
  output tword_t  stored_tag
);
  logic [TAG_WORD-1:0] bit_ok;
  logic [TAG_WORD-1:0] keep;

  for (genvar gi = 0; gi < TAG_WORD; gi++) begin : g_bit
    assign keep[gi]   = (gi < int'(width));
    assign bit_ok[gi] = !keep[gi] || (stored[gi] == tag[gi]);
  end

  assign match      = &bit_ok;
  assign stored_tag = stored & keep;
  assign dirty      = wb & stored[TAG_BASE];
endmodule

// File: rtl/l2tag_ctrl.sv
module l2tag_ctrl
  import l2tag_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                req_write,
  input  logic                req_pci,
  input  logic [1:0]          cfg_size,
  input  logic [1:0]          cfg_tag_mode,
  input  logic                cfg_wb,
  input  logic [TAG_WORD-1:0] tag_rdata,
  input  logic                victim_ack,
  output logic [IDX_W-1:0]    tag_idx,
  output logic [TAG_WORD-1:0] tag_wdata,
  output logic                tag_we,
  output logic                resp_done,
  output logic                resp_hit,
  output logic                resp_pci,
  output logic                dram_wr_req,
  output logic                victim_req,
  output logic [ADDR_W-1:0]   victim_addr
);
  state_t  state;
  addr_t   addr_q;
  logic    write_q, pci_q;
  addr_t   addr_sel;
  idx_t    dec_idx;
  tword_t  dec_tag, stored_tag;
  twidth_t dec_width;
  logic    cacheable, match, dirty;

  // request address is decoded straight from the port while idle, then held
  assign addr_sel = (state == ST_IDLE) ? req_addr : addr_q;
  assign tag_idx  = dec_idx;

  l2tag_decode u_decode (
    .addr      (addr_sel),
    .size      (cfg_size),
    .mode      (cfg_tag_mode),
    .wb        (cfg_wb),
    .idx       (dec_idx),
    .tag       (dec_tag),
    .width     (dec_width),
    .cacheable (cacheable)
  );

  l2tag_compare u_compare (
    .stored     (tag_rdata),
    .tag        (dec_tag),
    .width      (dec_width),
    .wb         (cfg_wb),
    .match      (match),
    .dirty      (dirty),
    .stored_tag (stored_tag)
  );

  // named events for the checks below
  logic ev_accept, ev_look, ev_hit, ev_write_hit, ev_alloc, ev_victim, ev_uncache;
  tword_t dirty_word;
  assign ev_accept    = (state == ST_IDLE) && req_valid;
  assign ev_look      = (state == ST_LOOK);
  assign ev_uncache   = ev_look && !cacheable;
  assign ev_hit       = ev_look && cacheable && match;
  assign ev_write_hit = ev_hit && write_q;
  assign ev_alloc     = ev_look && cacheable && !match && !write_q;
  assign ev_victim    = ev_alloc && dirty;
  assign dirty_word   = dec_tag | (tword_t'(1) << TAG_BASE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      addr_q      <= '0;
      write_q     <= 1'b0;
      pci_q       <= 1'b0;
      tag_wdata   <= '0;
      tag_we      <= 1'b0;
      resp_done   <= 1'b0;
      resp_hit    <= 1'b0;
      resp_pci    <= 1'b0;
      dram_wr_req <= 1'b0;
      victim_req  <= 1'b0;
      victim_addr <= '0;
    end else begin
      resp_done   <= 1'b0;
      resp_hit    <= 1'b0;
      tag_we      <= 1'b0;
      dram_wr_req <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (ev_accept) begin
            addr_q  <= req_addr;
            write_q <= req_write;
            pci_q   <= req_pci;
            state   <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (ev_victim) begin
            victim_req  <= 1'b1;
            victim_addr <= f_line(stored_tag, dec_idx, cfg_size);
            tag_wdata   <= dec_tag;
            state       <= ST_VICT;
          end else begin
            resp_done   <= 1'b1;
            resp_hit    <= ev_hit;
            resp_pci    <= pci_q;
            tag_we      <= ev_alloc || (ev_write_hit && cfg_wb);
            tag_wdata   <= ev_write_hit ? dirty_word : dec_tag;
            dram_wr_req <= write_q && !(ev_hit && cfg_wb);
            state       <= ST_RESP;
          end
        end
        ST_VICT: begin
          if (victim_ack) begin
            victim_req <= 1'b0;
            resp_done  <= 1'b1;
            resp_pci   <= pci_q;
            tag_we     <= 1'b1;
            state      <= ST_RESP;
          end
        end
        ST_RESP: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: completion is a single-cycle pulse
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    resp_done |=> !resp_done);

  // R3: an uncacheable lookup never changes the tag store
  p_uncache_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_uncache |=> (!tag_we && !victim_req && !resp_hit));

  // R5: a read hit writes neither tag nor DRAM
  p_read_hit_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hit && !write_q) |=> (resp_hit && !tag_we && !dram_wr_req));

  // R6: write-through write hit goes to DRAM
  p_wt_write_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_write_hit && !cfg_wb) |=> (dram_wr_req && !tag_we));

  // R7: writeback write hit marks the line, no DRAM write
  p_wb_write_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_write_hit && cfg_wb) |=> (tag_we && tag_wdata[TAG_BASE] && !dram_wr_req));

  // R8: tag writes only happen with the completion pulse
  p_we_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tag_we |-> resp_done);

  // R10: victim request holds until acknowledged
  p_victim_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (victim_req && !victim_ack) |=> victim_req);

  // R10: release of the victim request brings the clean tag write
  p_victim_then_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(victim_req) |-> (tag_we && resp_done && !tag_wdata[TAG_BASE]));
endmodule

// File: tb/test_l2tag_ctrl.sv
module test_l2tag_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_pci = 1'b0;
  logic [1:0]  cs = 2'd0;
  logic [1:0]  cm = 2'd0;
  logic        wb = 1'b0;
  logic [9:0]  tag_rdata = '0;
  logic        victim_ack = 1'b0;
  logic [15:0] tag_idx;
  logic [9:0]  tag_wdata;
  logic        tag_we, resp_done, resp_hit, resp_pci, dram_wr_req, victim_req;
  logic [31:0] victim_addr;

  int nchk = 0;
  int nerr = 0;
  int sram  [int];
  int model [int];

  always #5 clk = ~clk;

  l2tag_ctrl i_l2tag_ctrl (
    .clk, .rst_n, .req_valid, .req_addr, .req_write, .req_pci,
    .cfg_size(cs), .cfg_tag_mode(cm), .cfg_wb(wb),
    .tag_rdata, .victim_ack, .tag_idx, .tag_wdata, .tag_we,
    .resp_done, .resp_hit, .resp_pci, .dram_wr_req, .victim_req, .victim_addr
  );

  // tag SRAM: one-cycle synchronous read
  always @(posedge clk) begin
    tag_rdata <= sram.exists(int'(tag_idx)) ? 10'(sram[int'(tag_idx)]) : 10'd0;
    if (tag_we) sram[int'(tag_idx)] = int'(tag_wdata);
  end

  task automatic check(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  task automatic preload(input int idx, input int word);
    sram[idx] = word;
    model[idx] = word;
  endtask

  // one request, reference outcome computed from the requirements
  task automatic do_req(input longint a, input bit wr, input bit pci,
                        input bit poke, input int ack_delay);
    int shift, w, idx, tg, st;
    longint lim, vaddr;
    bit cach, match, hit, dirty, e_we, e_dram, e_vict;
    int e_wd;
    shift = 18 + int'(cs);
    w     = wb ? 7 : 7 + int'(cm);
    idx   = int'((a >> 5) % (longint'(1) << (13 + int'(cs))));
    tg    = int'((a >> shift) % (longint'(1) << w));
    lim   = (longint'(1) << (shift + w)) - (longint'(1) << shift);
    cach  = a < lim;
    st    = model.exists(idx) ? model[idx] : 0;
    match = (st % (1 << w)) == tg;
    hit   = cach && match;
    dirty = wb && (((st >> 7) & 1) == 1);
    e_vict = cach && !match && !wr && dirty;
    e_we   = (cach && !match && !wr) || (hit && wr && wb);
    e_wd   = (hit && wr) ? (tg + 128) : tg;
    e_dram = wr && !(hit && wb);
    vaddr  = (longint'(st % 128) << shift) + (longint'(idx) << 5);

    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'(a); req_write = wr; req_pci = pci;
    #1 check("R1 tag_idx", tag_idx, idx);
    @(negedge clk);
    req_valid = poke;
    if (poke) begin req_addr = 32'(a) ^ 32'h0000_0040; req_write = !wr; end
    check("R4 done early", resp_done, 0);
    @(negedge clk);
    if (e_vict) begin
      check("R10 victim_req", victim_req, 1);
      check("R10 victim_addr", victim_addr, vaddr);
      check("R10 no done before ack", resp_done, 0);
      for (int k = 0; k < ack_delay; k++) begin
        @(negedge clk);
        check("R10 victim held", victim_req, 1);
        check("R10 done waits", resp_done, 0);
      end
      victim_ack = 1'b1;
      @(negedge clk);
      victim_ack = 1'b0;
      check("R10 victim released", victim_req, 0);
    end else begin
      check("R3 no victim", victim_req, 0);
    end
    check("R4 done pulse", resp_done, 1);
    check(hit ? "R5 hit flag" : "R3 R8 miss flag", resp_hit, hit);
    check(wr ? "R6 R9 tag write" : "R8 tag write", tag_we, e_we);
    if (e_we) check(wr ? "R7 modify word" : "R8 fill word", tag_wdata, e_wd);
    check(wr ? "R6 R7 R9 dram" : "R5 dram", dram_wr_req, e_dram);
    check("R11 source", resp_pci, pci);
    if (e_we) model[idx] = e_wd;
    @(negedge clk);
    req_valid = 1'b0;
    check("R4 done one cycle", resp_done, 0);
    check("R4 tag_we one cycle", tag_we, 0);
    if (poke) begin
      repeat (2) begin
        @(negedge clk);
        check("R4 busy request ignored", resp_done, 0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R4 reset done", resp_done, 0);
    check("R8 reset tag_we", tag_we, 0);
    check("R10 reset victim", victim_req, 0);
    check("R9 reset dram", dram_wr_req, 0);
    rst_n = 1'b1;

    // write-through, 256 KB, 7-bit tag
    cs = 2'd0; cm = 2'd0; wb = 1'b0;
    do_req(64'h0012_3460, 0, 0, 0, 0);   // R8 allocate
    do_req(64'h0012_3460, 0, 0, 0, 0);   // R5 hit
    do_req(64'h0012_3460, 1, 0, 0, 0);   // R6 write hit
    do_req(64'h0052_3460, 1, 0, 0, 0);   // R9 write miss, same index
    do_req(64'h0012_3460, 0, 1, 0, 0);   // R11 PCI hit
    preload(32'h801, 32'h201);           // R2 stray bit 9 above tag
    do_req(64'h0005_0020, 0, 0, 0, 0);
    do_req(64'h01FC_0000, 0, 0, 0, 0);   // R3 exactly at limit
    do_req(64'h01FC_0000, 1, 0, 0, 0);   // R9 uncacheable write
    do_req(64'h01FB_FFE0, 0, 0, 0, 0);   // R3 just below limit

    // write-through, 2 MB, 10-bit tag
    cs = 2'd3; cm = 2'd3;
    do_req(64'h7FDF_FFE0, 0, 1, 0, 0);
    do_req(64'h7FDF_FFE0, 0, 0, 0, 0);
    do_req(64'h7FE0_0000, 0, 0, 0, 0);   // R3 limit for 10-bit tag
    cs = 2'd1; cm = 2'd1;                // R2 512 KB, 8-bit tag
    do_req(64'h0123_4560, 0, 0, 0, 0);
    do_req(64'h0123_4560, 0, 0, 0, 0);

    // writeback, 1 MB; mode value must be ignored (R7)
    cs = 2'd2; cm = 2'd2; wb = 1'b1;
    do_req(64'h0234_5680, 0, 0, 0, 0);   // R8 allocate clean
    do_req(64'h0234_5680, 1, 1, 1, 0);   // R7 mark, R4 busy poke
    do_req(64'h0234_5680, 1, 0, 0, 0);   // R7 second write keeps flag
    do_req(64'h0A34_5680, 0, 0, 0, 0);   // R7 bit 27 beyond 7-bit tag: uncacheable
    do_req(64'h0244_5680, 1, 0, 0, 0);   // R9 write miss in writeback
    do_req(64'h0244_5680, 0, 0, 0, 2);   // R10 dirty victim
    do_req(64'h0244_5680, 0, 1, 0, 0);   // R5 hit after fill
    do_req(64'h0234_5680, 0, 0, 0, 0);   // R8 clean replace, no victim

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule